// File: doc/BRIEF.md
# External Bus Cycle Strobe Sequencer

This block runs the pin-level cycle for one external memory or peripheral region. A CPU-side request carries an address, a write flag, a size (byte, halfword or word) and write data. The sequencer answers by driving chip select, the read and write strobes, a data-drive enable, the bus address and the bus write data. When the access is over it returns the assembled read data together with a one-cycle done pulse.

All timing comes from two configuration words. The region word holds separate strobe lengths for reads and writes, enables for four optional phases, the bus width and an address-increment switch. The common word holds the four phase lengths, and several regions can share it. An access wider than the bus is split into beats, and chip select stays low from the first beat to the last. Both words are captured when a request is accepted, so software can reprogram them at any time without disturbing the access in flight.

Each beat is a lead phase, then a strobe phase, then a tail phase. Lead has chip select active and both strobes idle. Strobe has the read or write strobe active. Tail has the strobe released and chip select still active. An optional idle recovery phase follows the last beat.

Top module: `ebs_sequencer`

## Requirements
- R1: `req_ready` is high only when no access or recovery is in progress, and chip select is inactive whenever it is high. A `req_valid` seen while `req_ready` is low is ignored and starts no access.
- R2: The strobe of each beat lasts N+1 cycles. N is region bits [3:0] for writes and region bits [7:4] for reads. Only one of the two strobes is active at a time.
- R3: Chip select goes active in the cycle after acceptance, and at least one cycle before any strobe. The lead phase lasts 1 cycle, plus common bits [15:12] cycles when region bit 11 is set.
- R4: For a write, the tail lasts 1 cycle, plus common bits [7:4] cycles when region bit 9 is set. `bus_oe` is high for every chip-select-active cycle of a write.
- R5: For a read, the tail lasts 1 cycle, plus common bits [11:8] cycles when region bit 10 is set. `bus_oe` stays low throughout a read. Each beat's read data is sampled at the clock edge that ends its tail.
- R6: When region bit 8 is set, `req_ready` stays low for common bits [3:0] cycles, counted from the done cycle. When the bit is clear, `req_ready` is high in the done cycle.
- R7: Region bit 12 selects the bus width (0 = 8-bit, 1 = 16-bit). Size 0 is a byte, size 1 a halfword and sizes 2 and 3 a word. This gives 1, 2 or 4 beats on an 8-bit bus and 1, 1 or 2 beats on a 16-bit bus. Chip select falls once and stays low across all beats.
- R8: When region bit 13 is set, beat k drives `req_addr` + k times the bus width in bytes; when it is clear, every beat drives `req_addr`. Read beat k fills `rdata` bits [8k+7:8k] on an 8-bit bus, or bits [16k+15:16k] on a 16-bit bus, taken from the low lanes of `bus_rdata`. Unfilled bits are zero.
- R9: With all region bits zero, a single byte access holds chip select active for exactly 3 cycles.
- R10: `done` is a one-cycle pulse in the first cycle after chip select goes inactive, and `rdata` is valid in that cycle.
- R11: A change to `region_cfg` or `common_cfg` during an access has no effect on that access.
- R12: Write beat k drives `req_wdata` bits [16k+15:16k] on a 16-bit bus. On an 8-bit bus it drives bits [8k+7:8k] in the low byte, with the upper byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | ADDR_W | Start address |
| req_wdata | input | 32 | Write data |
| region_cfg | input | 14 | Region delay, phase enable, width and increment bits |
| common_cfg | input | 16 | Shared recovery, hold, float and lead lengths |
| req_ready | output | 1 | Sequencer idle |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 32 | Assembled read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Write-data drive enable |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |

## Verification
On a read, the capture of the last beat's data and the release of chip select happen at the same clock edge. That edge also raises done, and it can start recovery. Multi-beat reads with a stretched float phase provoke this overlap, and so does a zero-delay read. The bench changes the bus data at each strobe start and checks that `rdata` in the done cycle holds every beat in its correct lane. A second overlap is a reprogramming or a new request arriving while an access runs. The bench judges it by the lengths and pulse counts measured at the pins, which must still match the values captured at acceptance.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int WORD_W    = 32;
  localparam int BUS_W     = 16;
  localparam int REGION_W  = 14;
  localparam int COMMON_W  = 16;
  localparam int LEN_W     = 5;
  localparam int IDX_W     = $clog2(WORD_W / 8);

  // region word bit positions
  localparam int WR_LSB    = 0;
  localparam int RD_LSB    = 4;
  localparam int REC_BIT   = 8;
  localparam int HOLD_BIT  = 9;
  localparam int FLT_BIT   = 10;
  localparam int PRE_BIT   = 11;
  localparam int WIDE_BIT  = 12;
  localparam int INC_BIT   = 13;
  // common word field positions
  localparam int C_REC_LSB  = 0;
  localparam int C_HOLD_LSB = 4;
  localparam int C_FLT_LSB  = 8;
  localparam int C_PRE_LSB  = 12;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEAD, PH_STRB, PH_TAIL, PH_RECV
  } phase_t;

  function automatic logic [LEN_W-1:0] lead_cycles(
    input logic [REGION_W-1:0] rc, input logic [COMMON_W-1:0] cc);
    return LEN_W'(1) + (rc[PRE_BIT] ? LEN_W'(cc[C_PRE_LSB +: 4]) : LEN_W'(0));
  endfunction

  function automatic logic [LEN_W-1:0] strobe_cycles(
    input logic [REGION_W-1:0] rc, input logic wr);
    return LEN_W'(1) + LEN_W'(wr ? rc[WR_LSB +: 4] : rc[RD_LSB +: 4]);
  endfunction

  function automatic logic [LEN_W-1:0] tail_cycles(
    input logic [REGION_W-1:0] rc, input logic [COMMON_W-1:0] cc, input logic wr);
    logic [LEN_W-1:0] t;
    t = LEN_W'(1);
    if (wr && rc[HOLD_BIT])  t = t + LEN_W'(cc[C_HOLD_LSB +: 4]);
    if (!wr && rc[FLT_BIT])  t = t + LEN_W'(cc[C_FLT_LSB +: 4]);
    return t;
  endfunction

  function automatic logic [3:0] recovery_cycles(
    input logic [REGION_W-1:0] rc, input logic [COMMON_W-1:0] cc);
    return rc[REC_BIT] ? cc[C_REC_LSB +: 4] : 4'd0;
  endfunction

  function automatic logic [IDX_W:0] beat_total(input logic [1:0] size, input logic wide);
    case (size)
      2'd0:    return (IDX_W+1)'(1);
      2'd1:    return wide ? (IDX_W+1)'(1) : (IDX_W+1)'(2);
      default: return wide ? (IDX_W+1)'(2) : (IDX_W+1)'(4);
    endcase
  endfunction
endpackage

// File: rtl/ebs_timing.sv
module ebs_timing
  import ebs_pkg::*;
(
  input  logic [REGION_W-1:0] rc,
  input  logic [COMMON_W-1:0] cc,
  input  logic                wr,
  input  logic [1:0]          size,
  output logic [LEN_W-1:0]    lead_len,
  output logic [LEN_W-1:0]    strb_len,
  output logic [LEN_W-1:0]    tail_len,
  output logic [3:0]          rec_len,
  output logic [IDX_W:0]      beats,
  output logic                wide,
  output logic                incr
);
  always_comb begin
    lead_len = lead_cycles(rc, cc);
    strb_len = strobe_cycles(rc, wr);
    tail_len = tail_cycles(rc, cc, wr);
    rec_len  = recovery_cycles(rc, cc);
    wide     = rc[WIDE_BIT];
    incr     = rc[INC_BIT];
    beats    = beat_total(size, rc[WIDE_BIT]);
  end
endmodule

// File: rtl/ebs_lane.sv
module ebs_lane
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic              wide,
  input  logic              incr,
  input  logic [IDX_W-1:0]  beat,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int SH_W = IDX_W + 4;

  logic [SH_W-1:0]         bit_sh;
  logic [WORD_W+BUS_W-1:0] wpad;
  logic [WORD_W-1:0]       lane_in;
  logic [WORD_W-1:0]       rdata_q;

  assign bit_sh = wide ? {beat, 4'b0000} : {1'b0, beat, 3'b000};
  assign wpad   = {{BUS_W{1'b0}}, wdata};

  always_comb begin
    bus_addr = base_addr;
    if (incr) bus_addr = base_addr + (wide ? ADDR_W'({beat, 1'b0}) : ADDR_W'(beat));
    bus_wdata = wide ? wpad[bit_sh +: BUS_W] : {{(BUS_W-8){1'b0}}, wpad[bit_sh +: 8]};
    lane_in   = wide ? WORD_W'(bus_rdata) : WORD_W'(bus_rdata[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (clear)   rdata_q <= '0;
    else if (capture) rdata_q <= rdata_q | (lane_in << bit_sh);
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ebs_sequencer.sv
module ebs_sequencer
  import ebs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  input  logic [REGION_W-1:0] region_cfg,
  input  logic [COMMON_W-1:0] common_cfg,
  output logic                req_ready,
  output logic                done,
  output logic [WORD_W-1:0]   rdata,
  output logic                bus_cs_n,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic                bus_oe,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [BUS_W-1:0]    bus_wdata,
  input  logic [BUS_W-1:0]    bus_rdata
);
  phase_t              phase_q;
  logic [LEN_W-1:0]    cnt_q;
  logic [IDX_W-1:0]    beat_q;
  logic [REGION_W-1:0] rc_q;
  logic [COMMON_W-1:0] cc_q;
  logic                wr_q;
  logic [1:0]          size_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   wdata_q;
  logic                done_q;

  logic [LEN_W-1:0] lead_len, strb_len, tail_len, cur_len;
  logic [3:0]       rec_len;
  logic [IDX_W:0]   beats;
  logic             wide, incr;

  // named events
  logic accept, phase_end, last_beat, tail_end, access_end, capture, cs_active;

  ebs_timing u_timing (
    .rc(rc_q), .cc(cc_q), .wr(wr_q), .size(size_q),
    .lead_len(lead_len), .strb_len(strb_len), .tail_len(tail_len),
    .rec_len(rec_len), .beats(beats), .wide(wide), .incr(incr)
  );

  always_comb begin
    case (phase_q)
      PH_LEAD: cur_len = lead_len;
      PH_STRB: cur_len = strb_len;
      PH_TAIL: cur_len = tail_len;
      PH_RECV: cur_len = LEN_W'(rec_len);
      default: cur_len = LEN_W'(1);
    endcase
  end

  assign accept     = (phase_q == PH_IDLE) && req_valid;
  assign phase_end  = (cnt_q == LEN_W'(cur_len - LEN_W'(1)));
  assign last_beat  = ({1'b0, beat_q} == (IDX_W+1)'(beats - (IDX_W+1)'(1)));
  assign tail_end   = (phase_q == PH_TAIL) && phase_end;
  assign access_end = tail_end && last_beat;
  assign capture    = tail_end && !wr_q;
  assign cs_active  = (phase_q == PH_LEAD) || (phase_q == PH_STRB) || (phase_q == PH_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      rc_q    <= '0;
      cc_q    <= '0;
      wr_q    <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= access_end;
      if (accept) begin
        rc_q    <= region_cfg;
        cc_q    <= common_cfg;
        wr_q    <= req_write;
        size_q  <= req_size;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        beat_q  <= '0;
        cnt_q   <= '0;
        phase_q <= PH_LEAD;
      end else if (phase_q != PH_IDLE) begin
        if (phase_end) begin
          cnt_q <= '0;
          case (phase_q)
            PH_LEAD: phase_q <= PH_STRB;
            PH_STRB: phase_q <= PH_TAIL;
            PH_TAIL: begin
              if (last_beat) begin
                phase_q <= (rec_len != 4'd0) ? PH_RECV : PH_IDLE;
              end else begin
                beat_q  <= beat_q + IDX_W'(1);
                phase_q <= PH_LEAD;
              end
            end
            default: phase_q <= PH_IDLE;
          endcase
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
        end
      end
    end
  end

  ebs_lane #(.ADDR_W(ADDR_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .clear(accept), .capture(capture),
    .wide(wide), .incr(incr), .beat(beat_q), .base_addr(addr_q),
    .wdata(wdata_q), .bus_rdata(bus_rdata), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rdata(rdata)
  );

  assign req_ready = (phase_q == PH_IDLE);
  assign done      = done_q;
  assign bus_cs_n  = !cs_active;
  assign bus_rd_n  = !((phase_q == PH_STRB) && !wr_q);
  assign bus_wr_n  = !((phase_q == PH_STRB) && wr_q);
  assign bus_oe    = cs_active && wr_q;
endmodule

// File: rtl/ebs_sequencer_chk.sv
module ebs_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic bus_cs_n,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_oe,
  input logic accept
);
  // R1
  ready_cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs_n);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R3
  cs_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(!bus_cs_n));

  // R3
  accept_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!bus_cs_n && bus_rd_n && bus_wr_n));

  // R5
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);

  // R7
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_cs_n && $past(!bus_cs_n)));
endmodule

bind ebs_sequencer ebs_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_oe(bus_oe), .accept(accept)
);

// File: tb/ebs_sequencer_bench.sv
module ebs_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0] req_wdata;
  logic [13:0] region_cfg;
  logic [15:0] common_cfg;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic        bus_cs_n, bus_rd_n, bus_wr_n, bus_oe;
  logic [ADDR_W-1:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  ebs_sequencer #(.ADDR_W(ADDR_W)) u_ebs_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .region_cfg(region_cfg), .common_cfg(common_cfg), .req_ready(req_ready),
    .done(done), .rdata(rdata), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_oe(bus_oe), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int m_cs;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] beat_data(input int k);
    return 16'h1234 + 16'(k) * 16'h2121;
  endfunction

  task automatic do_access(input logic wr, input logic [1:0] size, input logic [ADDR_W-1:0] addr,
                           input logic [31:0] wdata, input logic [13:0] cfg, input logic [15:0] com,
                           input int chg_at, input logic [13:0] alt, input int poke_at);
    int beats, bb, exp_l, exp_s, exp_t, exp_r;
    int cs_cyc, falls, strobes, strb_cyc, lead, tail, oe_bad, rec, k, addr_bad, wd_bad;
    bit wide, inc, prev_cs, prev_strb, strb, seen;
    logic [ADDR_W-1:0] got_addr [4];
    logic [15:0] got_wd [4];
    logic [31:0] exp_rd, sh;
    wide  = cfg[12];
    inc   = cfg[13];
    beats = (size == 0) ? 1 : (size == 1) ? (wide ? 1 : 2) : (wide ? 2 : 4);
    bb    = (wide && size != 0) ? 2 : 1;
    exp_l = 1 + (cfg[11] ? int'(com[15:12]) : 0);
    exp_s = 1 + (wr ? int'(cfg[3:0]) : int'(cfg[7:4]));
    exp_t = 1 + ((wr && cfg[9]) ? int'(com[7:4]) : 0) + ((!wr && cfg[10]) ? int'(com[11:8]) : 0);
    exp_r = cfg[8] ? int'(com[3:0]) : 0;
    cs_cyc = 0; falls = 0; strobes = 0; strb_cyc = 0; lead = 0; tail = 0; oe_bad = 0;
    k = 0; prev_cs = 1; prev_strb = 0; seen = 0;

    while (!req_ready) @(negedge clk);
    req_write = wr; req_size = size; req_addr = addr; req_wdata = wdata;
    region_cfg = cfg; common_cfg = com; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (n == chg_at) begin region_cfg = alt; common_cfg = ~com; end
      if (n == poke_at) begin req_valid = 1'b1; req_write = !wr; end
      else req_valid = 1'b0;
      strb = !bus_rd_n || !bus_wr_n;
      if (!bus_cs_n) begin
        cs_cyc++;
        if (prev_cs) falls++;
        if (bus_oe != wr) oe_bad++;
      end else if (bus_oe) oe_bad++;
      if (strb) begin
        strb_cyc++;
        tail = 0;
        if (!prev_strb) begin
          strobes++;
          if (k < 4) begin
            got_addr[k] = bus_addr;
            got_wd[k]   = bus_wdata;
            if (!wr) bus_rdata = beat_data(k);
            k++;
          end
        end
      end else if (!bus_cs_n) begin
        if (k == 0) lead++;
        else tail++;
      end
      prev_cs = bus_cs_n; prev_strb = strb;
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    req_valid = 1'b0;

    chk(seen, "R10 done seen", 32'(seen), 1);
    chk(bus_cs_n, "R10 cs inactive at done", 32'(bus_cs_n), 1);
    chk(cs_cyc == beats * (exp_l + exp_s + exp_t), "R2 cs active cycles", cs_cyc, beats * (exp_l + exp_s + exp_t));
    chk(falls == 1, "R7 single cs fall", falls, 1);
    chk(strobes == beats, "R7 strobe count", strobes, beats);
    chk(strb_cyc == beats * exp_s, "R2 strobe cycles", strb_cyc, beats * exp_s);
    chk(lead == exp_l, "R3 lead cycles", lead, exp_l);
    chk(tail == exp_t, wr ? "R4 hold tail" : "R5 float tail", tail, exp_t);
    chk(oe_bad == 0, wr ? "R4 drive enable" : "R5 drive enable", oe_bad, 0);
    addr_bad = 0; wd_bad = 0; exp_rd = 0;
    for (int i = 0; i < beats && i < k; i++) begin
      if (got_addr[i] != addr + ADDR_W'(inc ? i * bb : 0)) addr_bad++;
      sh = wdata >> (wide ? 16 * i : 8 * i);
      if (got_wd[i] != (wide ? sh[15:0] : {8'h00, sh[7:0]})) wd_bad++;
      if (wide) exp_rd = exp_rd | (32'(beat_data(i)) << (16 * i));
      else      exp_rd = exp_rd | (32'(beat_data(i)) & 32'hFF) << (8 * i);
    end
    chk(addr_bad == 0, "R8 beat addresses", addr_bad, 0);
    if (wr) chk(wd_bad == 0, "R12 beat write data", wd_bad, 0);
    else    chk(rdata == exp_rd, "R8 assembled read data", rdata, exp_rd);
    rec = req_ready ? 0 : 1;
    @(negedge clk);
    chk(!done, "R10 done one cycle", 32'(done), 0);
    while (!req_ready && rec < 100) begin rec++; @(negedge clk); end
    chk(rec == exp_r, "R6 recovery cycles", rec, exp_r);
    m_cs = cs_cyc;
  endtask

  task automatic t_reset();
    chk(req_ready && bus_cs_n && bus_rd_n && bus_wr_n && !bus_oe && !done,
        "R1 reset state", {26'd0, req_ready, bus_cs_n, bus_rd_n, bus_wr_n, bus_oe, done}, 32'h3C);
  endtask

  task automatic t_zero_byte();
    do_access(1'b0, 2'd0, 24'h000100, 32'h0, 14'h0000, 16'h0000, -1, 14'h0, -1);
    chk(m_cs == 3, "R9 zero config byte", m_cs, 3);
  endtask

  task automatic t_read_word_8();
    do_access(1'b0, 2'd2, 24'h001000, 32'h0, 14'h2052, 16'h0000, -1, 14'h0, -1);
  endtask

  task automatic t_write_word_16();
    do_access(1'b1, 2'd2, 24'h002000, 32'hCAFE_F00D, 14'h3A03, 16'h3720, -1, 14'h0, -1);
  endtask

  task automatic t_read_noinc_float();
    do_access(1'b0, 2'd2, 24'h003003, 32'h0, 14'h0410, 16'h0490, -1, 14'h0, -1);
  endtask

  task automatic t_write_word_8();
    do_access(1'b1, 2'd3, 24'h004000, 32'h8899_AABB, 14'h2201, 16'h0050, -1, 14'h0, -1);
  endtask

  task automatic t_recovery();
    do_access(1'b0, 2'd1, 24'h005000, 32'h0, 14'h2100, 16'h0006, -1, 14'h0, -1);
  endtask

  task automatic t_cfg_change();
    do_access(1'b0, 2'd2, 24'h006000, 32'h0, 14'h2033, 16'h0000, 1, 14'h1FFF, -1);
    chk(m_cs == 2 * (1 + 4 + 1) * 2, "R11 config held", m_cs, 24);
  endtask

  task automatic t_busy_ignore();
    int cs_seen;
    do_access(1'b1, 2'd0, 24'h007000, 32'h0000_005A, 14'h0044, 16'h0000, -1, 14'h0, 2);
    cs_seen = 0;
    for (int i = 0; i < 6; i++) begin
      if (!bus_cs_n || !req_ready) cs_seen++;
      @(negedge clk);
    end
    chk(cs_seen == 0, "R1 busy request ignored", cs_seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; region_cfg = '0; common_cfg = '0; bus_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_byte();
    t_read_word_8();
    t_write_word_16();
    t_read_noinc_float();
    t_write_word_8();
    t_recovery();
    t_cfg_change();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule